// File: doc/BRIEF.md
# Decode-Stage Branch Resolver and Fetch Steering

This block controls the fetch side of a five-stage in-order pipeline in which conditional branches are settled in the decode stage rather than in execute. It holds the fetch program counter and the fetch-to-decode register, which carries the instruction word, its address and a valid flag. It takes the branch kind that the decoder extracts from the instruction now in decode, along with the value of the single register the branch tests and the 16-bit word offset. A zero/nonzero test and a dedicated target adder, both in decode, decide the branch in the same cycle that it is decoded.

A policy input chooses how the cycle after a branch is spent. Policy 0, stall: the instruction fetched behind the branch is thrown away and fetched again on the resolved path, which costs exactly one cycle whether or not the branch is taken. Policy 1, predict not taken: fetch continues in order, and a taken branch turns the word already fetched into a bubble. Policy 2, delay slot: the word after the branch always goes on to execute, and fetch then continues at the resolved address with no lost cycle. The policy is captured while reset is high. A data-hazard hold from decode freezes both the counter and the fetch-to-decode register, and it outranks any branch action in the same cycle.

Top module: `efc_top`

## Requirements
- R1: While reset is high and in the first cycle after it, the fetch PC equals RESET_PC (default 0), the decode entry is invalid with an all-zero word, and flush and fetch stall are low.
- R2: Branch kind encoding: 2'b01 is taken when the tested register is zero, 2'b10 is taken when it is nonzero, and 2'b00 and 2'b11 are not branches. A branch is considered only while the decode entry is valid.
- R3: The branch target is the decode entry's PC plus 4 plus the sign-extended 16-bit offset shifted left by two, and it is computed for both positive and negative offsets.
- R4: With policy 2'b00 (stall, also used for 2'b11), a branch in decode raises flush and fetch stall. The next PC is the target when taken, or the current fetch PC when not taken, so the successor is fetched again.
- R5: With policy 2'b01 (predict not taken), a not-taken branch leaves fetch sequential with no flush. A taken branch raises flush, leaves fetch stall low and sets the next PC to the target.
- R6: With policy 2'b10 (delay slot), a branch never raises flush. The word behind it enters decode as valid, and the next PC is the target when taken or the fetch PC plus 4 when not taken.
- R7: After a flush edge, the decode entry is invalid and its instruction word is all zeros.
- R8: While the hazard hold is high, the fetch PC and the decode entry keep their values, flush is low, fetch stall is high, and no redirect occurs, even with a taken branch in decode.
- R9: The policy input is captured only while reset is high. A change after reset has no effect on branch handling.
- R10: When no branch or hold is active, the next PC is the fetch PC plus 4, each edge loads the fetched word into decode as valid, and the fetch PC always takes the value next_pc_o had before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the policy |
| policy_i | input | 2 | Branch policy: 0 stall, 1 predict not taken, 2 delay slot |
| imem_word_i | input | 32 | Instruction word fetched at fetch_pc_o |
| hazard_hold_i | input | 1 | Data-hazard hold from decode |
| br_kind_i | input | 2 | Branch kind decoded from the decode entry |
| br_reg_i | input | 32 | Value of the register the branch tests |
| br_off_i | input | 16 | Signed word offset of the branch |
| fetch_pc_o | output | 32 | Current fetch PC |
| next_pc_o | output | 32 | PC that fetch loads at the next edge |
| dec_word_o | output | 32 | Instruction word in the fetch-to-decode register |
| dec_pc_o | output | 32 | PC of the decode entry |
| dec_valid_o | output | 1 | Decode entry holds a live instruction |
| flush_o | output | 1 | Fetched word is replaced by a bubble at the next edge |
| fetch_stall_o | output | 1 | Fetch is held for a hazard or for the stall policy |

## Verification
Two events can fall in the same cycle: a taken branch being resolved in decode and a data-hazard hold from decode. To provoke this, the bench places a taken branch in decode under the predict-not-taken policy and raises the hold at the same time. It then expects no flush, an unchanged PC and an unchanged decode entry. When the hold is released with the branch still present, the bench expects the redirect and the bubble to appear exactly one cycle later. The bench also changes the policy input after reset, to show that branch handling stays as it was set at reset.

// File: rtl/efc_pkg.sv
package efc_pkg;

    parameter int unsigned XLEN     = 32;
    parameter int unsigned INSTR_W  = 32;
    parameter int unsigned PC_STEP  = 4;

    typedef enum logic [1:0] {
        POL_STALL = 2'b00,
        POL_PNT   = 2'b01,
        POL_DELAY = 2'b10
    } policy_e;

    typedef enum logic [1:0] {
        BK_NONE = 2'b00,
        BK_EQZ  = 2'b01,
        BK_NEZ  = 2'b10,
        BK_RSVD = 2'b11
    } brkind_e;

    typedef struct packed {
        logic            active;
        logic            taken;
        logic [XLEN-1:0] target;
    } resolve_t;

    typedef struct packed {
        logic               valid;
        logic [XLEN-1:0]    pc;
        logic [INSTR_W-1:0] word;
    } fd_entry_t;

    function automatic policy_e decode_policy(input logic [1:0] raw);
        case (raw)
            2'b01:   return POL_PNT;
            2'b10:   return POL_DELAY;
            default: return POL_STALL;
        endcase
    endfunction

    function automatic logic is_branch(input brkind_e k);
        return (k == BK_EQZ) || (k == BK_NEZ);
    endfunction

    function automatic logic cond_true(input brkind_e k, input logic [XLEN-1:0] v);
        logic zero;
        zero = (v == '0);
        case (k)
            BK_EQZ:  return zero;
            BK_NEZ:  return !zero;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/efc_resolve.sv
module efc_resolve
    import efc_pkg::*;
#(
    parameter int unsigned OFF_W = 16
) (
    input  logic             entry_valid,
    input  brkind_e          kind,
    input  logic [XLEN-1:0]  test_val,
    input  logic [XLEN-1:0]  branch_pc,
    input  logic [OFF_W-1:0] offset,
    output resolve_t         res
);
    localparam int unsigned SHIFT = 2;
    localparam int unsigned EXT_W = XLEN - OFF_W;

    logic [XLEN-1:0] off_ext;
    logic [XLEN-1:0] off_bytes;
    logic [XLEN-1:0] seq_pc;

    always_comb begin
        off_ext   = {{EXT_W{offset[OFF_W-1]}}, offset};
        off_bytes = off_ext << SHIFT;
        seq_pc    = branch_pc + XLEN'(PC_STEP);
    end

    always_comb begin
        res.active = entry_valid && is_branch(kind);
        res.taken  = res.active && cond_true(kind, test_val);
        res.target = seq_pc + off_bytes;
    end

endmodule

// File: rtl/efc_steer.sv
module efc_steer
    import efc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  policy_e         policy,
    input  resolve_t        res,
    input  logic            hazard_hold,
    input  logic [XLEN-1:0] fetch_pc,
    output logic [XLEN-1:0] next_pc,
    output logic            flush,
    output logic            fetch_stall
);
    logic [XLEN-1:0] seq_next;
    logic            act;

    always_comb begin
        seq_next    = fetch_pc + XLEN'(PC_STEP);
        act         = res.active && !hazard_hold;
        next_pc     = seq_next;
        flush       = 1'b0;
        fetch_stall = hazard_hold;
        if (hazard_hold) begin
            next_pc = fetch_pc;
        end else if (act) begin
            case (policy)
                POL_PNT: begin
                    flush   = res.taken;
                    next_pc = res.taken ? res.target : seq_next;
                end
                POL_DELAY: begin
                    next_pc = res.taken ? res.target : seq_next;
                end
                default: begin
                    flush       = 1'b1;
                    fetch_stall = 1'b1;
                    next_pc     = res.taken ? res.target : fetch_pc;
                end
            endcase
        end
    end

    AST_FLUSH_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (rst)
        flush |-> res.active);  // R5
    AST_NO_FLUSH_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        hazard_hold |-> (!flush && next_pc == fetch_pc));  // R8

endmodule

// File: rtl/efc_fetch_regs.sv
module efc_fetch_regs
    import efc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic               flush,
    input  logic [XLEN-1:0]    next_pc,
    input  logic [INSTR_W-1:0] fetched_word,
    output logic [XLEN-1:0]    pc_q,
    output fd_entry_t          fd_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= RESET_PC;
            fd_q     <= '0;
        end else begin
            pc_q <= next_pc;
            if (!hold) begin
                if (flush) begin
                    fd_q.valid <= 1'b0;
                    fd_q.word  <= '0;
                    fd_q.pc    <= pc_q;
                end else begin
                    fd_q.valid <= 1'b1;
                    fd_q.word  <= fetched_word;
                    fd_q.pc    <= pc_q;
                end
            end
        end
    end

    AST_FLUSH_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (flush && !hold) |=> (!fd_q.valid && fd_q.word == '0));  // R7
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(fd_q) && $stable(pc_q)));  // R8

endmodule

// File: rtl/efc_top.sv
module efc_top
    import efc_pkg::*;
#(
    parameter int unsigned     OFF_W    = 16,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         policy_i,
    input  logic [INSTR_W-1:0] imem_word_i,
    input  logic               hazard_hold_i,
    input  logic [1:0]         br_kind_i,
    input  logic [XLEN-1:0]    br_reg_i,
    input  logic [OFF_W-1:0]   br_off_i,
    output logic [XLEN-1:0]    fetch_pc_o,
    output logic [XLEN-1:0]    next_pc_o,
    output logic [INSTR_W-1:0] dec_word_o,
    output logic [XLEN-1:0]    dec_pc_o,
    output logic               dec_valid_o,
    output logic               flush_o,
    output logic               fetch_stall_o
);
    policy_e   mode_q;
    resolve_t  res;
    fd_entry_t fd;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] nxt;
    logic            flush;
    logic            fstall;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= decode_policy(policy_i);
    end

    efc_resolve #(.OFF_W(OFF_W)) u_resolve (
        .entry_valid (fd.valid),
        .kind        (brkind_e'(br_kind_i)),
        .test_val    (br_reg_i),
        .branch_pc   (fd.pc),
        .offset      (br_off_i),
        .res         (res)
    );

    efc_steer u_steer (
        .clk         (clk),
        .rst         (rst),
        .policy      (mode_q),
        .res         (res),
        .hazard_hold (hazard_hold_i),
        .fetch_pc    (pc),
        .next_pc     (nxt),
        .flush       (flush),
        .fetch_stall (fstall)
    );

    efc_fetch_regs #(.RESET_PC(RESET_PC)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .hold         (hazard_hold_i),
        .flush        (flush),
        .next_pc      (nxt),
        .fetched_word (imem_word_i),
        .pc_q         (pc),
        .fd_q         (fd)
    );

    assign fetch_pc_o    = pc;
    assign next_pc_o     = nxt;
    assign dec_word_o    = fd.word;
    assign dec_pc_o      = fd.pc;
    assign dec_valid_o   = fd.valid;
    assign flush_o       = flush;
    assign fetch_stall_o = fstall;

    AST_PC_TRACKS_NEXT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fetch_pc_o == $past(next_pc_o)));  // R10
    AST_DELAY_NEVER_FLUSHES: assert property (@(posedge clk) disable iff (rst)
        (mode_q == POL_DELAY) |-> !flush_o);  // R6
    AST_POLICY_FROZEN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));  // R9

endmodule

// File: tb/efc_top_test.sv
module efc_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  policy = 2'b00;
    logic [31:0] imem;
    logic        hold = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic [31:0] regv = '0;
    logic [15:0] off = '0;
    logic [31:0] fetch_pc, next_pc, dec_word, dec_pc;
    logic        dec_valid, flush, fstall;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [31:0] BPC = 32'h10;

    always #2.5 clk = ~clk;

    assign imem = {16'hC0DE, fetch_pc[15:0]};

    efc_top uut (
        .clk(clk), .rst(rst), .policy_i(policy), .imem_word_i(imem),
        .hazard_hold_i(hold), .br_kind_i(kind), .br_reg_i(regv), .br_off_i(off),
        .fetch_pc_o(fetch_pc), .next_pc_o(next_pc), .dec_word_o(dec_word),
        .dec_pc_o(dec_pc), .dec_valid_o(dec_valid), .flush_o(flush),
        .fetch_stall_o(fstall)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] tgt(input logic [15:0] o);
        return BPC + 32'd4 + ({{16{o[15]}}, o} << 2);
    endfunction

    task automatic do_reset(input logic [1:0] m);
        kind = 2'b00; hold = 1'b0; policy = m; rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        #0.5;
    endtask

    task automatic reach_branch();
        int n = 0;
        while (!(dec_valid && dec_pc == BPC) && n < 50) begin
            @(negedge clk); n++;
        end
    endtask

    // Reset values and sequential flow
    task automatic t_reset_and_seq();
        kind = 2'b00; hold = 1'b0; policy = 2'b00; rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1", "pc in reset", fetch_pc, 32'h0);
        chk("R1", "valid in reset", {31'b0, dec_valid}, 0);
        chk("R1", "word in reset", dec_word, 0);
        chk("R1", "flush/stall in reset", {30'b0, flush, fstall}, 0);
        rst = 1'b0;
        #0.5;
        chk("R10", "seq next", next_pc, 32'h4);
        @(negedge clk);
        chk("R10", "pc advanced", fetch_pc, 32'h4);
        chk("R10", "decode loaded", {31'b0, dec_valid}, 1);
        chk("R10", "decode word", dec_word, 32'hC0DE0000);
        kind = 2'b11; regv = 0; #0.5;
        chk("R2", "reserved kind no redirect", next_pc, 32'h8);
        chk("R2", "reserved kind no flush", {31'b0, flush}, 0);
        kind = 2'b00;
    endtask

    task automatic t_branch(input string req, input logic [1:0] m, input logic [1:0] k,
                            input logic [31:0] rv, input logic [15:0] o, input bit taken);
        logic [31:0] exp_next;
        bit exp_flush, exp_stall;
        do_reset(m);
        reach_branch();
        kind = k; regv = rv; off = o;
        #0.5;
        case (m)
            2'b01: begin exp_flush = taken; exp_stall = 0;
                         exp_next = taken ? tgt(o) : BPC + 32'd8; end
            2'b10: begin exp_flush = 0; exp_stall = 0;
                         exp_next = taken ? tgt(o) : BPC + 32'd8; end
            default: begin exp_flush = 1; exp_stall = 1;
                         exp_next = taken ? tgt(o) : BPC + 32'd4; end
        endcase
        chk(req, "next pc", next_pc, exp_next);
        chk(req, "flush", {31'b0, flush}, {31'b0, exp_flush});
        chk(req, "fetch stall", {31'b0, fstall}, {31'b0, exp_stall});
        @(negedge clk);
        kind = 2'b00;
        chk(req, "pc after edge", fetch_pc, exp_next);
        chk(req, "successor valid", {31'b0, dec_valid}, {31'b0, !exp_flush});
        if (exp_flush) chk("R7", "bubble word", dec_word, 0);
        else chk(req, "successor word", dec_word, {16'hC0DE, 16'h0014});
        @(negedge clk);
        chk(req, "resolved path in decode", dec_pc, exp_next);
        chk(req, "resolved path valid", {31'b0, dec_valid}, 1);
    endtask

    // Hazard hold and a taken branch in the same cycle
    task automatic t_hazard_collision();
        do_reset(2'b01);
        reach_branch();
        kind = 2'b01; regv = 0; off = 16'h0008; hold = 1'b1;
        #0.5;
        chk("R8", "no flush under hold", {31'b0, flush}, 0);
        chk("R8", "stall under hold", {31'b0, fstall}, 1);
        chk("R8", "next holds pc", next_pc, BPC + 32'd4);
        @(negedge clk);
        chk("R8", "pc held", fetch_pc, BPC + 32'd4);
        chk("R8", "decode held", dec_pc, BPC);
        chk("R8", "decode word held", dec_word, {16'hC0DE, 16'h0010});
        hold = 1'b0; #0.5;
        chk("R8", "redirect after release", next_pc, tgt(16'h0008));
        chk("R8", "flush after release", {31'b0, flush}, 1);
        @(negedge clk);
        kind = 2'b00;
        chk("R8", "pc at target", fetch_pc, tgt(16'h0008));
        chk("R7", "bubble after release", {31'b0, dec_valid}, 0);
    endtask

    // Policy change after reset is ignored
    task automatic t_policy_frozen();
        do_reset(2'b10);
        policy = 2'b00;
        reach_branch();
        kind = 2'b10; regv = 32'h5; off = 16'h0003;
        #0.5;
        chk("R9", "no flush after late change", {31'b0, flush}, 0);
        chk("R9", "delay redirect", next_pc, tgt(16'h0003));
        @(negedge clk);
        kind = 2'b00;
        chk("R9", "slot kept", {31'b0, dec_valid}, 1);
    endtask

    initial begin
        t_reset_and_seq();
        t_branch("R4", 2'b00, 2'b01, 32'h0, 16'h0010, 1'b1);
        t_branch("R4", 2'b00, 2'b01, 32'h7, 16'h0010, 1'b0);
        t_branch("R5", 2'b01, 2'b10, 32'h0, 16'h0010, 1'b0);
        t_branch("R5", 2'b01, 2'b10, 32'h1, 16'h0020, 1'b1);
        t_branch("R6", 2'b10, 2'b01, 32'h0, 16'h0006, 1'b1);
        t_branch("R6", 2'b10, 2'b10, 32'h0, 16'h0006, 1'b0);
        t_branch("R3", 2'b10, 2'b01, 32'h0, 16'hFFFE, 1'b1);
        t_branch("R2", 2'b01, 2'b01, 32'h8000_0000, 16'h0004, 1'b0);
        t_branch("R4", 2'b11, 2'b10, 32'h3, 16'h0004, 1'b1);
        t_hazard_collision();
        t_policy_frozen();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule